// File: doc/BRIEF.md
# Concurrent Bank Refresh Scheduler

This block picks, on every clock cycle, which banks of a multi-bank DRAM receive a refresh, so that refresh proceeds in parallel with ordinary read and write traffic instead of stealing whole cycles from it. Each bank has two independent select lines: one driven by the access path and one driven by this scheduler. The scheduler watches the access select vector and drives the refresh select vector.

Two one-hot ring pointers name the refresh candidates. One walks upward through the bank indices and the other walks downward, so up to two banks can be refreshed in the same cycle. The candidate vector is masked bit by bit with the access select of the same cycle, so a refresh is never placed on a bank that is being accessed. A pointer whose bank was masked keeps that bank and tries again on the next cycle. A done mask tracks the banks refreshed in the current round and raises a one-cycle pulse when every bank has been covered.

Top module: `conc_refresh_sched`

## Requirements
- R1: After reset the up-pointer is one-hot at bank 0 (bit 0), the down-pointer is one-hot at bank NB-1 (bit NB-1), and the round-done output is low.
- R2: While the refresh request is low, the refresh select is all zeros whatever the access select is, and neither pointer moves at the next edge.
- R3: While the refresh request is high, the refresh select equals the OR of the two pointers with every bank whose access select bit is high cleared, in the same cycle.
- R4: The refresh select and the access select never have a set bit in common.
- R5: The up-pointer rotates from bit i to bit i+1 (bit NB-1 wraps to bit 0) at an edge where the request is high and its bank is not accessed; otherwise it holds.
- R6: The down-pointer rotates from bit i to bit i-1 (bit 0 wraps to bit NB-1) at an edge where the request is high and its bank is not accessed; otherwise it holds.
- R7: When both pointers hold the same bank and that bank issues, exactly one refresh select bit is set and both pointers advance at the next edge.
- R8: Round-done is high for exactly the one cycle following the edge at which every bank has been refreshed since the previous round ended; the record is then cleared.
- R9: With a continuous request and a one-hot access select that moves each cycle, every bank is refreshed at least once in any window of 4*NB cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_req | input | 1 | Refresh wanted in this cycle |
| acc_sel | input | NB | One-hot or zero access bank select of this cycle |
| ref_sel | output | NB | Refresh bank select of this cycle |
| up_ptr | output | NB | One-hot upward refresh pointer |
| dn_ptr | output | NB | One-hot downward refresh pointer |
| round_done | output | 1 | One-cycle pulse after all banks were refreshed |

## Verification
The refresh select is a same-cycle function of the request, the access select and the pointers, so the bench compares it a short delay after driving inputs, before the next rising edge. Pointer moves and the round-done pulse appear one edge after the cycle that caused them, so the bench advances its reference model at that edge and compares the new values in the following cycle. The fairness bound is measured over a long moving-access run by counting request cycles between refreshes of each bank.

// File: rtl/conc_refresh_sched.sv
module conc_refresh_sched #(
  parameter int NB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_req,
  input  logic [NB-1:0] acc_sel,
  output logic [NB-1:0] ref_sel,
  output logic [NB-1:0] up_ptr,
  output logic [NB-1:0] dn_ptr,
  output logic          round_done
);

  localparam logic [NB-1:0] UP_INIT = NB'(1);
  localparam logic [NB-1:0] DN_INIT = UP_INIT << (NB - 1);

  function automatic logic [NB-1:0] rot_up(input logic [NB-1:0] v);
    return {v[NB-2:0], v[NB-1]};
  endfunction

  function automatic logic [NB-1:0] rot_dn(input logic [NB-1:0] v);
    return {v[0], v[NB-1:1]};
  endfunction

  logic [NB-1:0] cand, done_q, done_nx;
  logic          up_go, dn_go, all_done;

  assign cand     = up_ptr | dn_ptr;
  assign ref_sel  = ref_req ? (cand & ~acc_sel) : '0;
  assign up_go    = |(ref_sel & up_ptr);
  assign dn_go    = |(ref_sel & dn_ptr);
  assign done_nx  = done_q | ref_sel;
  assign all_done = &done_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_ptr     <= UP_INIT;
      dn_ptr     <= DN_INIT;
      done_q     <= '0;
      round_done <= 1'b0;
    end else begin
      if (up_go) up_ptr <= rot_up(up_ptr);
      if (dn_go) dn_ptr <= rot_dn(dn_ptr);
      done_q     <= all_done ? '0 : done_nx;
      round_done <= all_done;
    end
  end

  AST_UP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(up_ptr) == 1 && $countones(dn_ptr) == 1); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_req |=> $stable(up_ptr) && $stable(dn_ptr)); // R2
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !(|(up_ptr & acc_sel))) |=> up_ptr == rot_up($past(up_ptr))); // R5
  AST_DN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && |(dn_ptr & acc_sel)) |=> $stable(dn_ptr)); // R6
  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && up_ptr == dn_ptr && !(|(up_ptr & acc_sel))) |-> $countones(ref_sel) == 1); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    round_done |=> !round_done); // R8

endmodule

// File: tb/sim_conc_refresh_sched.sv
module sim_conc_refresh_sched;
  localparam int NB = 16;
  localparam int GAP_MAX = 4 * NB;

  logic clk = 1'b0, rst_n = 1'b0, ref_req = 1'b0;
  logic [NB-1:0] acc_sel = '0;
  logic [NB-1:0] ref_sel, up_ptr, dn_ptr;
  logic round_done;

  conc_refresh_sched #(.NB(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .acc_sel(acc_sel),
    .ref_sel(ref_sel), .up_ptr(up_ptr), .dn_ptr(dn_ptr), .round_done(round_done));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int m_up, m_dn, reqcyc, maxgap, rounds;
  logic [NB-1:0] m_mask;
  logic m_rd, track;
  int last_hit [NB];
  localparam logic [NB-1:0] ONE = NB'(1);

  task automatic chk(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic req, input logic [NB-1:0] acc);
    logic [NB-1:0] esel;
    int nu, nd;
    logic nrd;
    @(negedge clk);
    ref_req = req;
    acc_sel = acc;
    #2;
    esel = req ? (((ONE << m_up) | (ONE << m_dn)) & ~acc) : '0;
    chk(req ? "R3 refresh select" : "R2 idle select", ref_sel, esel);
    chk("R4 no overlap", ref_sel & acc_sel, '0);
    chk("R5 up pointer", up_ptr, ONE << m_up);
    chk("R6 down pointer", dn_ptr, ONE << m_dn);
    chk("R8 round done", NB'(round_done), NB'(m_rd));
    if (req && m_up == m_dn && !acc[m_up])
      chk("R7 single bit", NB'($countones(ref_sel)), NB'(1));
    if (req) begin
      reqcyc++;
      for (int b = 0; b < NB; b++) begin
        if (esel[b]) last_hit[b] = reqcyc;
        else if (track && reqcyc - last_hit[b] > maxgap) maxgap = reqcyc - last_hit[b];
      end
    end
    nu = (req && esel[m_up]) ? (m_up + 1) % NB : m_up;
    nd = (req && esel[m_dn]) ? (m_dn + NB - 1) % NB : m_dn;
    m_mask = m_mask | esel;
    nrd = &m_mask;
    if (nrd) m_mask = '0;
    @(posedge clk);
    m_up = nu;
    m_dn = nd;
    m_rd = nrd;
    if (nrd && track) rounds++;
  endtask

  initial begin
    #(8 * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_up = 0; m_dn = NB - 1; m_mask = '0; m_rd = 1'b0;
    reqcyc = 0; maxgap = 0; rounds = 0; track = 1'b0;
    for (int b = 0; b < NB; b++) last_hit[b] = 0;
    repeat (3) @(negedge clk);
    ref_req = 1'b1;
    acc_sel = '0;
    #1;
    chk("R1 reset up", up_ptr, ONE);
    chk("R1 reset down", dn_ptr, ONE << (NB - 1));
    chk("R1 reset done", NB'(round_done), '0);
    ref_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2: access traffic with no request leaves everything alone
    for (int k = 0; k < 6; k++) step(1'b0, ONE << ((k * 5) % NB));
    // R3 R8: free-running refresh completes rounds
    for (int k = 0; k < 20; k++) step(1'b1, '0);
    // R5: hold the up-pointer's bank until the down-pointer meets it
    for (int k = 0; k < 20; k++) step(1'b1, ONE << m_up);
    // R7: release the shared bank
    step(1'b1, '0);
    step(1'b1, '0);
    // R6: hold the down-pointer's bank
    for (int k = 0; k < 10; k++) step(1'b1, ONE << m_dn);
    for (int k = 0; k < 4; k++) step(1'b0, '0);

    // R9: moving access, bounded refresh gap
    for (int b = 0; b < NB; b++) last_hit[b] = reqcyc;
    track = 1'b1;
    for (int k = 0; k < 160; k++) step(1'b1, ONE << ((k * 3) % NB));
    track = 1'b0;
    tests++;
    if (maxgap > GAP_MAX) begin
      fails++;
      $display("FAIL R9 refresh gap: actual %0d expected <= %0d", maxgap, GAP_MAX);
    end
    tests++;
    if (rounds < 2) begin
      fails++;
      $display("FAIL R9 rounds: actual %0d expected >= 2", rounds);
    end

    // mixed traffic
    for (int k = 0; k < 300; k++)
      step(($urandom % 4) != 0, (($urandom % 3) == 0) ? '0 : ONE << ($urandom % NB));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule